// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a host bus reach a small bank of 8-bit audio codec control registers through two 32-bit words. Software writes a command word that holds an internal address, a byte of data and a write-request flag. If the flag is set, the bridge runs a multi-cycle internal write. While that write runs, the flag reads back as 1, and it clears itself when the write has landed. Software reads a register by loading only the address, with the flag clear, and then fetching the data word. The value in the data word follows the address through a fixed-length pipeline, so software must wait that many cycles before it trusts the value.

The bridge also holds the register bank itself: 28 registers with fixed reset values. Two of the addresses are reserved test locations, and they can be neither written nor read back. One register is a status-flag register. Two status inputs set its ramp-done bits, software clears those bits by writing, and a rise of either bit raises an interrupt flag.

Top module: `codec_regbridge`

## Requirements
- R1: After reset the command word reads 0, and each register 0..27 reads its default value: 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00 (hex, in address order).
- R2: The command word is selected by bus_sel=0. Bit 16 is the write request, bits 14:8 are the address and bits 7:0 are the data. It reads back as {busy at bit 16, latched address at 14:8, latched data at 7:0}, with every other bit 0. A host write with bus_sel=1 (the data word) has no effect. bus_rdata updates on the clock edge that samples bus_rd.
- R3: A command write with bit 16 set, accepted while idle, makes bit 16 read as 1 for exactly WR_CYCLES (default 4) cycles. The register is updated on the cycle that bit 16 clears.
- R4: A command write that arrives while bit 16 reads 1 is ignored. The latched address and data stay as they were, the write in progress completes unchanged, and the target of the ignored write keeps its value.
- R5: A command write with bit 16 clear loads the address and data fields and changes no register. The data word (bus_sel=1) shows the addressed register in bits 7:0 only RD_STAGES (default 6) cycles after the address is loaded. A read issued earlier returns the previously addressed value.
- R6: Addresses 20 and 21, and every address from 28 to 127, ignore writes and read as 0.
- R7: In the flag register at address 9, a one-cycle pulse on ramp_up_evt sets bit 3 and a pulse on ramp_dn_evt sets bit 2. A host write stores its data byte, so writing 0 clears those bits. A pulse that coincides with the write's update cycle wins for its bit.
- R8: The interrupt flag, seen on the irq port and at bit 8 of the data word, sets when a status pulse turns flag bit 3 or 2 from 0 to 1. A completed write to address 9 clears it, unless a new rise happens in the same cycle. A pulse on a bit that is already 1 does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe for the selected word |
| bus_rd | input | 1 | Host read strobe for the selected word |
| bus_sel | input | 1 | Word select: 0 command word, 1 data word |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Registered host read data |
| ramp_up_evt | input | 1 | Status pulse that sets flag bit 3 |
| ramp_dn_evt | input | 1 | Status pulse that sets flag bit 2 |
| irq | output | 1 | Interrupt flag, same value as data word bit 8 |

## Verification
The assertions assume WR_CYCLES is at least 1 and that the status inputs are synchronous pulses sampled on the same clock. They also assume the host issues at most one strobe per cycle, and that a write's register update is judged only in cycles where no status pulse lands. The stimulus drives each host access and each status pulse for exactly one cycle, on the falling edge. The only exception is the directed case that lines a pulse up with a write's update cycle on purpose. Random traffic covers reserved and out-of-range addresses as well as the flag register, and the expected values come from a bench model of the register bank.

// File: rtl/codec_bridge_pkg.sv
`timescale 1ns/1ps
package codec_bridge_pkg;

  // host-visible word layout (fixed by software)
  localparam int CB_AW      = 7;
  localparam int CB_DW      = 8;
  localparam int CB_GO_BIT  = 16;
  localparam int CB_ADR_LSB = 8;
  localparam int CB_IRQ_BIT = 8;

  typedef struct packed {
    logic [CB_AW-1:0] addr;
    logic [CB_DW-1:0] data;
  } cb_cmd_t;

  // power-on contents of the internal bank
  function automatic logic [CB_DW-1:0] reg_default(input int idx);
    case (idx)
      0:  return 8'h0c;
      1:  return 8'haa;
      2:  return 8'h78;
      5:  return 8'hff;
      6:  return 8'h03;
      7:  return 8'h51;
      8:  return 8'h3f;
      11, 12, 13, 14, 15, 16: return 8'h04;
      17, 18: return 8'h0a;
      22: return 8'hc0;
      23: return 8'h34;
      24: return 8'h07;
      25: return 8'h44;
      26: return 8'h1f;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cb_cmd_ctrl.sv
`timescale 1ns/1ps
module cb_cmd_ctrl
  import codec_bridge_pkg::*;
#(
  parameter int WR_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_go,
  input  cb_cmd_t          cmd_in,
  output logic             busy_o,
  output cb_cmd_t          cmd_q,
  output logic             commit_o
);

  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
    end else if (!busy_q && cmd_wr) begin
      cmd_q <= cmd_in;
      if (cmd_go) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(WR_CYCLES - 1);
      end
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == '0);

  // checker: length of a busy run
  logic [CW:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_go_sets_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && cmd_wr && cmd_go) |=> busy_q);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    run_q <= (CW+1)'(WR_CYCLES));

  p_busy_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cmd_wr) |=> $stable(cmd_q));

endmodule

// File: rtl/cb_reg_file.sv
`timescale 1ns/1ps
module cb_reg_file
  import codec_bridge_pkg::*;
#(
  parameter int NREG      = 28,
  parameter int FLAG_ADDR = 9,
  parameter int TEST_A0   = 20,
  parameter int TEST_A1   = 21,
  parameter int UP_BIT    = 3,
  parameter int DN_BIT    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CB_AW-1:0] wr_addr,
  input  logic [CB_DW-1:0] wr_data,
  input  logic             up_evt,
  input  logic             dn_evt,
  input  logic [CB_AW-1:0] rd_addr,
  output logic [CB_DW-1:0] rd_val,
  output logic             irq_o
);

  localparam int FW = NREG * CB_DW;

  logic [FW-1:0]    mem_flat;
  logic [CB_DW-1:0] set_mask;

  always_comb begin
    set_mask         = '0;
    set_mask[UP_BIT] = up_evt;
    set_mask[DN_BIT] = dn_evt;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == TEST_A0 || i == TEST_A1) begin : g_test
      assign mem_flat[i*CB_DW +: CB_DW] = '0;
    end else if (i == FLAG_ADDR) begin : g_flag
      logic [CB_DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= reg_default(i);
        else     q <= ((wr_en && wr_addr == CB_AW'(i)) ? wr_data : q) | set_mask;
      end
      assign mem_flat[i*CB_DW +: CB_DW] = q;
    end else begin : g_plain
      logic [CB_DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= reg_default(i);
        else if (wr_en && wr_addr == CB_AW'(i)) q <= wr_data;
      end
      assign mem_flat[i*CB_DW +: CB_DW] = q;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == CB_AW'(i)) rd_val = mem_flat[i*CB_DW +: CB_DW];
  end

  logic [CB_DW-1:0] flag_cur;
  logic             rise;
  logic             wr_flag;
  logic             irq_q;

  assign flag_cur = mem_flat[FLAG_ADDR*CB_DW +: CB_DW];
  assign rise     = |(set_mask & ~flag_cur);
  assign wr_flag  = wr_en && (wr_addr == CB_AW'(FLAG_ADDR));

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (rise)    irq_q <= 1'b1;
    else if (wr_flag) irq_q <= 1'b0;
  end
  assign irq_o = irq_q;

  p_test_regs_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !up_evt && !dn_evt &&
     (wr_addr == CB_AW'(TEST_A0) || wr_addr == CB_AW'(TEST_A1) ||
      int'(wr_addr) >= NREG)) |=> $stable(mem_flat));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    up_evt |=> mem_flat[FLAG_ADDR*CB_DW + UP_BIT]);

  p_irq_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && !up_evt && !dn_evt) |=> !irq_q);

endmodule

// File: rtl/cb_rd_pipe.sv
`timescale 1ns/1ps
module cb_rd_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/codec_regbridge.sv
`timescale 1ns/1ps
module codec_regbridge
  import codec_bridge_pkg::*;
#(
  parameter int NREG      = 28,
  parameter int WR_CYCLES = 4,
  parameter int RD_STAGES = 6,
  parameter int FLAG_ADDR = 9,
  parameter int TEST_A0   = 20,
  parameter int TEST_A1   = 21
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ramp_up_evt,
  input  logic        ramp_dn_evt,
  output logic        irq
);

  cb_cmd_t          cmd_in;
  cb_cmd_t          cmd_q;
  logic             busy;
  logic             commit;
  logic [CB_DW-1:0] rd_val;
  logic [CB_DW-1:0] rd_dly;
  logic             irq_int;
  logic             unused_wbits;

  assign cmd_in.addr  = bus_wdata[CB_ADR_LSB +: CB_AW];
  assign cmd_in.data  = bus_wdata[CB_DW-1:0];
  assign unused_wbits = ^{bus_wdata[31:CB_GO_BIT+1], bus_wdata[CB_GO_BIT-1]};

  cb_cmd_ctrl #(.WR_CYCLES(WR_CYCLES)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (bus_wr && !bus_sel),
    .cmd_go   (bus_wdata[CB_GO_BIT]),
    .cmd_in   (cmd_in),
    .busy_o   (busy),
    .cmd_q    (cmd_q),
    .commit_o (commit)
  );

  cb_reg_file #(
    .NREG(NREG), .FLAG_ADDR(FLAG_ADDR), .TEST_A0(TEST_A0), .TEST_A1(TEST_A1),
    .UP_BIT(3), .DN_BIT(2)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (commit),
    .wr_addr (cmd_q.addr),
    .wr_data (cmd_q.data),
    .up_evt  (ramp_up_evt),
    .dn_evt  (ramp_dn_evt),
    .rd_addr (cmd_q.addr),
    .rd_val  (rd_val),
    .irq_o   (irq_int)
  );

  cb_rd_pipe #(.W(CB_DW), .STAGES(RD_STAGES)) u_pipe (
    .clk (clk),
    .rst (rst),
    .d   (rd_val),
    .q   (rd_dly)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (bus_sel) bus_rdata <= {23'b0, irq_int, rd_dly};
      else         bus_rdata <= {15'b0, busy, 1'b0, cmd_q.addr, cmd_q.data};
    end
  end

  assign irq = irq_int;

endmodule

// File: tb/tb_codec_regbridge.sv
`timescale 1ns/1ps
module tb_codec_regbridge;

  localparam int WRC = 4;
  localparam int RDS = 6;

  logic        clk = 0;
  logic        rst = 1;
  logic        bus_wr = 0, bus_rd = 0, bus_sel = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        ramp_up_evt = 0, ramp_dn_evt = 0;
  logic        irq;

  int total = 0;
  int bad   = 0;

  logic [7:0] exp_mem [28];
  logic       exp_irq;

  always #10 clk = ~clk;

  codec_regbridge #(.WR_CYCLES(WRC), .RD_STAGES(RDS)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ramp_up_evt(ramp_up_evt), .ramp_dn_evt(ramp_dn_evt), .irq(irq)
  );

  function automatic logic [7:0] dflt(input int a);
    logic [7:0] t [28] = '{8'h0c, 8'haa, 8'h78, 8'h00, 8'h00, 8'hff, 8'h03, 8'h51,
                           8'h3f, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
                           8'h04, 8'h0a, 8'h0a, 8'h00, 8'h00, 8'h00, 8'hc0, 8'h34,
                           8'h07, 8'h44, 8'h1f, 8'h00};
    return t[a];
  endfunction

  function automatic bit writable(input int a);
    return (a < 28) && (a != 20) && (a != 21);
  endfunction

  function automatic logic [31:0] exp_data_word(input int a);
    return {23'b0, exp_irq, (a < 28) ? exp_mem[a] : 8'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // all tasks are entered at a falling edge and return at one
  task automatic host_write(input logic sel, input logic [31:0] d);
    bus_wr = 1; bus_sel = sel; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic host_read(input logic sel, output logic [31:0] v);
    bus_rd = 1; bus_sel = sel;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic wait_idle(output int nbusy);
    logic [31:0] v;
    nbusy = 0;
    for (int k = 0; k < 50; k++) begin
      host_read(0, v);
      if (!v[16]) break;
      nbusy++;
    end
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    int n;
    host_write(0, (32'd1 << 16) | (32'(a) << 8) | 32'(d));
    wait_idle(n);
    if (writable(a)) exp_mem[a] = d;
    if (a == 9) exp_irq = 0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    host_write(0, 32'(a) << 8);
    repeat (RDS + 1) @(negedge clk);
    host_read(1, v);
  endtask

  task automatic pulse(input logic up, input logic dn);
    ramp_up_evt = up; ramp_dn_evt = dn;
    @(negedge clk);
    ramp_up_evt = 0; ramp_dn_evt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 28; i++) exp_mem[i] = dflt(i);
    exp_irq = 0;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1: reset state
    host_read(0, v);
    chk("R1 command word after reset", v, 32'h0);
    for (int a = 0; a < 28; a++) begin
      rd_reg(a, v);
      chk("R1 default value", v, exp_data_word(a));
    end

    // R3: busy run length and commit
    host_write(0, 32'h0001_035a);
    wait_idle(n);
    chk("R3 busy cycles", 32'(n), 32'(WRC));
    exp_mem[3] = 8'h5a;
    rd_reg(3, v);
    chk("R3 written value", v, exp_data_word(3));

    // R2: field layout and data-word writes ignored
    wr_reg(6, 8'hc3);
    host_read(0, v);
    chk("R2 command readback", v, 32'h0000_06c3);
    host_write(1, 32'h0001_06ff);
    host_read(0, v);
    chk("R2 data-word write ignored", v, 32'h0000_06c3);
    repeat (RDS + 1) @(negedge clk);
    host_read(1, v);
    chk("R2 register unchanged by data-word write", v, exp_data_word(6));

    // R4: write while busy is dropped
    host_write(0, 32'h0001_0111);
    host_write(0, 32'h0001_0222);
    host_read(0, v);
    chk("R4 latched fields kept while busy", v, 32'h0001_0111);
    wait_idle(n);
    exp_mem[1] = 8'h11;
    rd_reg(1, v);
    chk("R4 first write landed", v, exp_data_word(1));
    rd_reg(2, v);
    chk("R4 dropped write target unchanged", v, exp_data_word(2));

    // R5: read latency and no-write address load
    rd_reg(5, v);
    host_write(0, 32'h0000_04ee);
    host_read(1, v);
    chk("R5 early read returns previous", v, exp_data_word(5));
    repeat (RDS + 1) @(negedge clk);
    host_read(1, v);
    chk("R5 settled read, no write", v, exp_data_word(4));

    // R6: reserved and out-of-range addresses
    wr_reg(20, 8'h55);
    rd_reg(20, v);
    chk("R6 test reg 20 reads zero", v, 32'h0);
    wr_reg(21, 8'hab);
    rd_reg(21, v);
    chk("R6 test reg 21 reads zero", v, 32'h0);
    wr_reg(100, 8'h99);
    rd_reg(100, v);
    chk("R6 out-of-range reads zero", v, 32'h0);
    rd_reg(19, v);
    chk("R6 neighbour untouched", v, exp_data_word(19));

    // R7 / R8: flag register and interrupt
    pulse(1, 0);
    exp_mem[9] = 8'h08; exp_irq = 1;
    rd_reg(9, v);
    chk("R7 up pulse sets bit3, R8 irq", v, 32'h0000_0108);
    chk("R8 irq port", 32'(irq), 32'd1);
    wr_reg(9, 8'h00);
    rd_reg(9, v);
    chk("R8 write clears irq, R7 bits cleared", v, 32'h0);
    pulse(0, 1);
    exp_mem[9] = 8'h04; exp_irq = 1;
    rd_reg(9, v);
    chk("R7 down pulse sets bit2", v, 32'h0000_0104);
    wr_reg(9, 8'h04);
    rd_reg(9, v);
    chk("R8 irq cleared, bit kept", v, 32'h0000_0004);
    pulse(0, 1);
    rd_reg(9, v);
    chk("R8 pulse on set bit no irq", v, 32'h0000_0004);
    host_write(0, 32'h0001_0900);
    repeat (WRC - 1) @(negedge clk);
    pulse(1, 0);
    wait_idle(n);
    exp_mem[9] = 8'h08; exp_irq = 1;
    rd_reg(9, v);
    chk("R7 pulse wins over write, R8 rise kept", v, 32'h0000_0108);
    wr_reg(9, 8'h00);

    // random traffic against the model (R3 R5 R6 R7)
    for (int it = 0; it < 60; it++) begin
      int a, b;
      logic [7:0] d;
      a = int'($urandom % 32);
      b = int'($urandom % 32);
      d = 8'($urandom);
      wr_reg(a, d);
      rd_reg(b, v);
      chk("R5 random readback", v, exp_data_word(b));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule